// File: doc/BRIEF.md
# Composite Peripheral Clock Enable Generator

The block turns four reference clock enables into one gated peripheral clock enable. All four references are single-cycle enable pulses, each derived from one fast system clock, so the whole block runs in that single clock domain. A 2-bit source field picks which reference the block follows. Two divide stages then run one after the other: the first counts pulses of the chosen reference, and the second counts pulses from the first. A gate sits at the end and passes or blocks the result.

Software sets the source field, the two 3-bit divisor fields and a gate-disable bit through a plain register-write port. The word address and bit position of each field are parameters. A divisor field of 1 to 6 divides by that value. A field of 0 or 7 is illegal: the output stays low and an error flag is raised. The block reports the effective total ratio (the product of the two stage divisors) on a status output. A new configuration is applied only at a period boundary, so no output period is ever shortened.

Top module: `pclk_composite`

## Requirements
- R1: The 2-bit source field sits in word 0x0 at bits [1:0]. Values 0, 1, 2 and 3 select `src_tick[0]` (primary A), `src_tick[1]` (primary B), `src_tick[2]` (secondary A) and `src_tick[3]` (secondary B). Pulses on the sources that are not selected have no effect.
- R2: With valid divisors d1 and d2, `out_tick` is high for one cycle after every d1*d2 pulses of the selected source. It is high in the cycle directly after the source pulse that completes the count.
- R3: The first-stage divisor field sits in word 0x4 at bits [5:3] and the second-stage field at bits [2:0]. A field value v from 1 to 6 divides that stage by v.
- R4: `ratio_out` shows the product of the two active stage divisors. It shows 0 when either active field is 0 or 7.
- R5: While either active divisor field is 0 or 7, `div_err` is high, `out_tick` stays low, and both stage counts are cleared.
- R6: Source and divisor fields written in the middle of an output period do not take effect until that period completes. At an idle period start (both counts at zero), or while in error, they take effect on the cycle after the write.
- R7: The gate-disable bit sits in word 0x14 at bit 2. Writing 1 blocks `out_tick` and writing 0 lets it through. The change takes effect from the second cycle after the write.
- R8: The gate state never changes in a cycle in which an output pulse is due, so an output pulse that is already due is never cut off.
- R9: Writes with `wr_en` low, and writes to any other word address (0x8, 0xC, 0x10), leave every field unchanged.
- R10: After reset the source is 0, both divisors are 1, the gate is open, `ratio_out` is 1, `div_err` is 0 and `out_tick` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_tick | input | 4 | Reference clock enable pulses, one per source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Byte address of the word being written |
| wr_data | input | 32 | Write data |
| out_tick | output | 1 | Gated divided clock enable pulse |
| div_err | output | 1 | An active divisor field is illegal |
| ratio_out | output | 6 | Effective total divide ratio, 0 when illegal |

## Verification
A register write lands on the clock edge where it is sampled. A new divisor or source then shows on `ratio_out` one edge later, as long as the divider is idle or in error. The gate bit needs one edge more. An output pulse is registered, so it shows one edge after the source pulse that completes the period. The bench drives every input on a falling edge and samples on the next falling edge. It waits two idle cycles after each configuration write before it checks the ratio or the error flag, and it checks `out_tick` against an arithmetic count of source pulses on every single pulse. The divisor sweep covers all 64 field pairs. Each valid pair gets exactly two full periods, which leaves both counts at zero for the next pair.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
  localparam int SEL_W   = 2;
  localparam int DIV_W   = 3;
  localparam int RATIO_W = 2 * DIV_W;
  localparam int NSRC    = 1 << SEL_W;

  // stage divisor for a field value; 0 marks an illegal field
  function automatic logic [DIV_W-1:0] stage_div(input logic [DIV_W-1:0] f);
    return (f >= 3'd1 && f <= 3'd6) ? f : '0;
  endfunction

  function automatic logic field_ok(input logic [DIV_W-1:0] f);
    return stage_div(f) != '0;
  endfunction

  function automatic logic [RATIO_W-1:0] total_ratio(input logic [DIV_W-1:0] a,
                                                     input logic [DIV_W-1:0] b);
    return RATIO_W'(stage_div(a)) * RATIO_W'(stage_div(b));
  endfunction
endpackage

// File: rtl/pclk_cfg_regs.sv
module pclk_cfg_regs
  import pclk_pkg::*;
#(
  parameter int AW        = 5,
  parameter int DW        = 32,
  parameter int SEL_ADDR  = 'h0,
  parameter int SEL_SHIFT = 0,
  parameter int D1_ADDR   = 'h4,
  parameter int D1_SHIFT  = 3,
  parameter int D2_ADDR   = 'h4,
  parameter int D2_SHIFT  = 0,
  parameter int GATE_ADDR = 'h14,
  parameter int GATE_BIT  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic [SEL_W-1:0] sel_f,
  output logic [DIV_W-1:0] d1_f,
  output logic [DIV_W-1:0] d2_f,
  output logic             dis_f
);
  logic hit_sel, hit_d1, hit_d2, hit_gate;

  assign hit_sel  = wr_en && (wr_addr == AW'(SEL_ADDR));
  assign hit_d1   = wr_en && (wr_addr == AW'(D1_ADDR));
  assign hit_d2   = wr_en && (wr_addr == AW'(D2_ADDR));
  assign hit_gate = wr_en && (wr_addr == AW'(GATE_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_f <= '0;
      d1_f  <= DIV_W'(1);
      d2_f  <= DIV_W'(1);
      dis_f <= 1'b0;
    end else begin
      if (hit_sel)  sel_f <= wr_data[SEL_SHIFT +: SEL_W];
      if (hit_d1)   d1_f  <= wr_data[D1_SHIFT +: DIV_W];
      if (hit_d2)   d2_f  <= wr_data[D2_SHIFT +: DIV_W];
      if (hit_gate) dis_f <= wr_data[GATE_BIT];
    end
  end
endmodule

// File: rtl/pclk_div_stage.sv
module pclk_div_stage
  import pclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick,
  output logic             zero_next
);
  logic [DIV_W-1:0] cnt, cnt_nx;
  logic             wrap;

  always_comb begin
    wrap = step && (cnt == DIV_W'(div - DIV_W'(1)));
    if (clr)       cnt_nx = '0;
    else if (wrap) cnt_nx = '0;
    else if (step) cnt_nx = cnt + DIV_W'(1);
    else           cnt_nx = cnt;
  end

  assign tick      = wrap && !clr;
  assign zero_next = (cnt_nx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nx;
  end
endmodule

// File: rtl/pclk_composite.sv
module pclk_composite
  import pclk_pkg::*;
#(
  parameter int AW        = 5,
  parameter int DW        = 32,
  parameter int SEL_ADDR  = 'h0,
  parameter int SEL_SHIFT = 0,
  parameter int D1_ADDR   = 'h4,
  parameter int D1_SHIFT  = 3,
  parameter int D2_ADDR   = 'h4,
  parameter int D2_SHIFT  = 0,
  parameter int GATE_ADDR = 'h14,
  parameter int GATE_BIT  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSRC-1:0]    src_tick,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  output logic               out_tick,
  output logic               div_err,
  output logic [RATIO_W-1:0] ratio_out
);
  logic [SEL_W-1:0] sel_f, act_sel;
  logic [DIV_W-1:0] d1_f, d2_f, act_d1, act_d2;
  logic             dis_f, gate_q, out_q;
  logic             err_act, src_pick, s1_tick, s2_tick, z1, z2, load_cfg;

  pclk_cfg_regs #(
    .AW(AW), .DW(DW), .SEL_ADDR(SEL_ADDR), .SEL_SHIFT(SEL_SHIFT),
    .D1_ADDR(D1_ADDR), .D1_SHIFT(D1_SHIFT), .D2_ADDR(D2_ADDR), .D2_SHIFT(D2_SHIFT),
    .GATE_ADDR(GATE_ADDR), .GATE_BIT(GATE_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sel_f(sel_f), .d1_f(d1_f), .d2_f(d2_f), .dis_f(dis_f)
  );

  assign err_act  = !field_ok(act_d1) || !field_ok(act_d2);
  assign src_pick = src_tick[act_sel];

  pclk_div_stage u_stage1 (
    .clk(clk), .rst_n(rst_n), .step(src_pick), .clr(err_act),
    .div(act_d1), .tick(s1_tick), .zero_next(z1)
  );

  pclk_div_stage u_stage2 (
    .clk(clk), .rst_n(rst_n), .step(s1_tick), .clr(err_act),
    .div(act_d2), .tick(s2_tick), .zero_next(z2)
  );

  // new settings only at a period start
  assign load_cfg = err_act || (z1 && z2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_sel <= '0;
      act_d1  <= DIV_W'(1);
      act_d2  <= DIV_W'(1);
    end else if (load_cfg) begin
      act_sel <= sel_f;
      act_d1  <= d1_f;
      act_d2  <= d2_f;
    end
  end

  // gate retimed: it never moves while a pulse is due
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      if (!s2_tick) gate_q <= dis_f;
      out_q <= s2_tick && !gate_q;
    end
  end

  assign out_tick  = out_q;
  assign div_err   = err_act;
  assign ratio_out = total_ratio(act_d1, act_d2);
endmodule

// File: rtl/pclk_composite_chk.sv
module pclk_composite_chk
  import pclk_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               err_act,
  input logic               out_tick,
  input logic [RATIO_W-1:0] ratio_out,
  input logic               gate_q,
  input logic               s2_tick,
  input logic               load_cfg,
  input logic [DIV_W-1:0]   act_d1,
  input logic [DIV_W-1:0]   act_d2,
  input logic [SEL_W-1:0]   act_sel
);
  assert_err_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_act |=> !out_tick);

  assert_err_ratio_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_act |-> ratio_out == '0);

  assert_ok_ratio_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !err_act |-> ratio_out != '0);

  assert_gate_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q |=> !out_tick);

  assert_gate_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    s2_tick |=> $stable(gate_q));

  assert_period_end_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s2_tick |-> load_cfg);

  assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_cfg |=> ($stable(act_d1) && $stable(act_d2) && $stable(act_sel)));
endmodule

bind pclk_composite pclk_composite_chk u_chk (
  .clk(clk), .rst_n(rst_n), .err_act(err_act), .out_tick(out_tick),
  .ratio_out(ratio_out), .gate_q(gate_q), .s2_tick(s2_tick), .load_cfg(load_cfg),
  .act_d1(act_d1), .act_d2(act_d2), .act_sel(act_sel)
);

// File: tb/pclk_composite_test.sv
module pclk_composite_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_tick = '0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        out_tick, div_err;
  logic [5:0]  ratio_out;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pclk_composite uut (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .out_tick(out_tick),
    .div_err(div_err), .ratio_out(ratio_out)
  );

  function automatic int dv(input int f);
    return (f >= 1 && f <= 6) ? f : 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    wr_en = 1'b1; wr_addr = 5'(addr); wr_data = 32'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int idx, input int exp, input string req);
    src_tick = 4'(1 << idx);
    @(negedge clk);
    src_tick = '0;
    check(req, int'(out_tick), exp);
    @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R10 reset state
    check("R10 ratio", int'(ratio_out), 1);
    check("R10 err", int'(div_err), 0);
    check("R10 out", int'(out_tick), 0);
    pulse(0, 1, "R10 src0 divide by 1");

    // R1 source select sweep
    for (int s = 0; s < 4; s++) begin
      wr('h0, s);
      idle(2);
      for (int j = 0; j < 4; j++) pulse(j, (j == s) ? 1 : 0, "R1 select");
    end
    wr('h0, 0);
    idle(2);

    // R2 R3 R4 R5 exhaustive divisor sweep
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        int n;
        n = dv(a) * dv(b);
        wr('h4, (a << 3) | b);
        idle(2);
        check("R4 ratio", int'(ratio_out), n);
        check("R5 err flag", int'(div_err), (n == 0) ? 1 : 0);
        if (n == 0) begin
          for (int i = 0; i < 4; i++) pulse(0, 0, "R5 held low");
        end else begin
          for (int i = 0; i < 2 * n; i++)
            pulse(0, ((i + 1) % n == 0) ? 1 : 0, "R2 R3 count");
        end
      end
    end

    // R6 mid-period change is deferred
    wr('h4, (3 << 3) | 1);
    idle(2);
    check("R6 ratio 3", int'(ratio_out), 3);
    pulse(0, 0, "R6 old period");
    wr('h4, (2 << 3) | 1);
    idle(2);
    check("R6 still old ratio", int'(ratio_out), 3);
    pulse(0, 0, "R6 old period");
    pulse(0, 1, "R6 old period ends");
    check("R6 new ratio", int'(ratio_out), 2);
    pulse(0, 0, "R6 new period");
    pulse(0, 1, "R6 new period ends");

    // R7 gate
    wr('h4, (1 << 3) | 1);
    idle(2);
    wr('h14, 1 << 2);
    idle(2);
    pulse(0, 0, "R7 gated");
    pulse(0, 0, "R7 gated");
    wr('h14, 0);
    idle(2);
    pulse(0, 1, "R7 open");

    // R8 gate written in the same cycle a pulse is due does not cut it
    wr_en = 1'b1; wr_addr = 5'h14; wr_data = 32'(1 << 2); src_tick = 4'b0001;
    @(negedge clk);
    wr_en = 1'b0; src_tick = '0;
    check("R8 due pulse kept", int'(out_tick), 1);
    idle(2);
    pulse(0, 0, "R8 then gated");
    wr('h14, 0);
    idle(2);

    // R9 ignored writes
    wr_addr = 5'h4; wr_data = 32'h3f;
    @(negedge clk);
    idle(1);
    check("R9 wr_en low", int'(ratio_out), 1);
    wr('h8, -1);
    wr('hC, -1);
    wr('h10, -1);
    idle(2);
    check("R9 other words ratio", int'(ratio_out), 1);
    check("R9 other words err", int'(div_err), 0);
    pulse(0, 1, "R9 select and gate kept");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule